// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock and Operand Forwarding Control

This block sits beside the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the opcode and two source fields of the instruction being decoded. It also looks at the opcode and the two candidate destination fields of the instructions now in execute, memory and write-back. From the opcodes it works out which register each older instruction will write, and whether it writes at all. It also works out which sources the decoding instruction really reads. It then decides whether decode must be held for one cycle, or which pipeline stage should supply each operand in place of the register file.

The logic is purely combinational and has no handshake. The stall and select outputs are plain control levels that the surrounding pipeline samples at its own clock edge. The parameter `FULL_BYPASS` chooses between two variants. With it set to 0, every read-after-write dependence stalls. With it set to 1 (the default), values are forwarded from the youngest producer, and only a load still in execute forces a bubble. In both variants, a taken conditional branch in execute cancels the stall, because the instruction in decode is about to be discarded.

Top module: `hz_ctrl`

## Requirements
- R1: Opcode codes are NOP=0, ALU=1, ALUI=2, LW=3, SW=4, BEQZ=5, BNEZ=6, J=7, JAL=8, JR=9, JALR=10, and codes 11 to 15 are undefined. The destination of an older instruction is its rd field for ALU, its rt field for ALUI and LW, and the highest-numbered register (31 at the default width) for JAL and JALR.
- R2: ALU, ALUI and LW count as writers only when their destination is not register 0. JAL and JALR always write. NOP, SW, BEQZ, BNEZ, J, JR and the undefined codes never write.
- R3: The first source (rs) is read by ALU, ALUI, LW, SW, BEQZ, BNEZ, JR and JALR. The second source (rt) is read only by ALU and SW. All other codes read nothing, and an unread source never causes a stall or a forward.
- R4: A source matches a stage when that source is read, the stage's instruction writes, and its destination equals the source field.
- R5: With FULL_BYPASS=0, `stall` is 1 when either source matches execute, memory or write-back, and both forwarding selects are 0 (register file).
- R6: With FULL_BYPASS=1, `stall` is 1 only when a source matches an LW in execute.
- R7: With FULL_BYPASS=1, each select is coded 0 for the register file, 1 for execute, 2 for memory and 3 for write-back. The youngest matching stage wins. An execute-stage match selects 1 unless that instruction is LW, in which case the select is 0. Memory and write-back forward any writer, loads included.
- R8: `stall` is 0 whenever execute holds BEQZ with `ex_zero`=1 or BNEZ with `ex_zero`=0. The forwarding selects are not affected by this.
- R9: Register 0 never matches a source, and a NOP bubble in any later stage never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Opcode of the instruction in decode |
| dec_rs | input | REG_W | First source field in decode |
| dec_rt | input | REG_W | Second source field in decode |
| ex_op | input | 4 | Opcode in execute |
| ex_rt | input | REG_W | rt field in execute |
| ex_rd | input | REG_W | rd field in execute |
| ex_zero | input | 1 | Zero flag of the execute-stage branch operand |
| mem_op | input | 4 | Opcode in memory |
| mem_rt | input | REG_W | rt field in memory |
| mem_rd | input | REG_W | rd field in memory |
| wb_op | input | 4 | Opcode in write-back |
| wb_rt | input | REG_W | rt field in write-back |
| wb_rd | input | REG_W | rd field in write-back |
| stall | output | 1 | Hold decode and insert a bubble into execute |
| fwd_a | output | 2 | Source stage for the first operand |
| fwd_b | output | 2 | Source stage for the second operand |

## Verification
The checker's assertions are sampled on settled combinational values. They assume that each opcode input is a 4-bit code, possibly an undefined one, and that the bubble in a stage is presented as opcode 0. They also assume that `ex_zero` is meaningful only while execute holds a branch. The stimulus walks through every combination of opcodes 0 to 11 across the four stages with both zero-flag values. Each register field is drawn from {0, 1, 2, 31}, which makes matches, register-0 aliases and link-register hits all frequent. Both variants see the same vectors.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned N_LATE = 3;   // execute, memory, write-back
  localparam int unsigned ST_EX  = 0;
  localparam int unsigned ST_MEM = 1;
  localparam int unsigned ST_WB  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_ALU  = 4'd1,
    OP_ALUI = 4'd2,
    OP_LW   = 4'd3,
    OP_SW   = 4'd4,
    OP_BEQZ = 4'd5,
    OP_BNEZ = 4'd6,
    OP_J    = 4'd7,
    OP_JAL  = 4'd8,
    OP_JR   = 4'd9,
    OP_JALR = 4'd10
  } op_e;

  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_EX  = 2'd1;
  localparam logic [1:0] SEL_MEM = 2'd2;
  localparam logic [1:0] SEL_WB  = 2'd3;
endpackage

// File: rtl/hz_dest_dec.sv
module hz_dest_dec
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [OP_W-1:0]  op,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] ws,
  output logic             wr_fwd,   // writer whose value can be forwarded
  output logic             wr_hold   // writer that must stall from execute
);
  localparam logic [REG_W-1:0] LINK_REG = '1;

  always_comb begin
    ws      = '0;
    wr_fwd  = 1'b0;
    wr_hold = 1'b0;
    case (op)
      OP_ALU:  begin ws = rd; wr_fwd = (rd != '0); end
      OP_ALUI: begin ws = rt; wr_fwd = (rt != '0); end
      OP_LW:   begin ws = rt; wr_hold = (rt != '0); end
      OP_JAL,
      OP_JALR: begin ws = LINK_REG; wr_fwd = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_src_dec.sv
module hz_src_dec
  import hz_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output logic            rd_en_s,
  output logic            rd_en_t
);
  always_comb begin
    rd_en_s = 1'b0;
    rd_en_t = 1'b0;
    case (op)
      OP_ALU, OP_SW: begin rd_en_s = 1'b1; rd_en_t = 1'b1; end
      OP_ALUI, OP_LW, OP_BEQZ, OP_BNEZ, OP_JR, OP_JALR: rd_en_s = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_opnd_ctl.sv
module hz_opnd_ctl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W       = 5,
  parameter bit          FULL_BYPASS = 1'b1
) (
  input  logic [REG_W-1:0]             src,
  input  logic                         rd_en,
  input  logic [N_LATE-1:0][REG_W-1:0] ws,
  input  logic [N_LATE-1:0]            wr_fwd,
  input  logic [N_LATE-1:0]            wr_hold,
  output logic                         need_stall,
  output logic [1:0]                   sel
);
  logic [N_LATE-1:0] hit;

  for (genvar g = 0; g < N_LATE; g++) begin : g_hit
    assign hit[g] = rd_en && (src == ws[g]) && (wr_fwd[g] || wr_hold[g]);
  end

  if (FULL_BYPASS) begin : g_fwd
    assign need_stall = hit[ST_EX] && wr_hold[ST_EX];
    always_comb begin
      if (hit[ST_EX])       sel = wr_hold[ST_EX] ? SEL_RF : SEL_EX;
      else if (hit[ST_MEM]) sel = SEL_MEM;
      else if (hit[ST_WB])  sel = SEL_WB;
      else                  sel = SEL_RF;
    end
  end else begin : g_lock
    assign need_stall = |hit;
    assign sel        = SEL_RF;
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W       = 5,
  parameter bit          FULL_BYPASS = 1'b1
) (
  input  logic [OP_W-1:0]  dec_op,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic [OP_W-1:0]  ex_op,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_zero,
  input  logic [OP_W-1:0]  mem_op,
  input  logic [REG_W-1:0] mem_rt,
  input  logic [REG_W-1:0] mem_rd,
  input  logic [OP_W-1:0]  wb_op,
  input  logic [REG_W-1:0] wb_rt,
  input  logic [REG_W-1:0] wb_rd,
  output logic             stall,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b
);
  localparam int unsigned N_OPND = 2;

  logic [N_LATE-1:0][OP_W-1:0]  st_op;
  logic [N_LATE-1:0][REG_W-1:0] st_rt, st_rd, st_ws;
  logic [N_LATE-1:0]            st_fwd, st_hold;

  assign st_op = {wb_op, mem_op, ex_op};
  assign st_rt = {wb_rt, mem_rt, ex_rt};
  assign st_rd = {wb_rd, mem_rd, ex_rd};

  for (genvar g = 0; g < N_LATE; g++) begin : g_dst
    hz_dest_dec #(.REG_W(REG_W)) u_dst (
      .op      (st_op[g]),
      .rt      (st_rt[g]),
      .rd      (st_rd[g]),
      .ws      (st_ws[g]),
      .wr_fwd  (st_fwd[g]),
      .wr_hold (st_hold[g])
    );
  end

  logic rd_en_s, rd_en_t;
  hz_src_dec u_src (
    .op      (dec_op),
    .rd_en_s (rd_en_s),
    .rd_en_t (rd_en_t)
  );

  logic [N_OPND-1:0][REG_W-1:0] o_src;
  logic [N_OPND-1:0]            o_en, o_stall;
  logic [N_OPND-1:0][1:0]       o_sel;

  assign o_src = {dec_rt, dec_rs};
  assign o_en  = {rd_en_t, rd_en_s};

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    hz_opnd_ctl #(.REG_W(REG_W), .FULL_BYPASS(FULL_BYPASS)) u_opnd (
      .src        (o_src[k]),
      .rd_en      (o_en[k]),
      .ws         (st_ws),
      .wr_fwd     (st_fwd),
      .wr_hold    (st_hold),
      .need_stall (o_stall[k]),
      .sel        (o_sel[k])
    );
  end

  logic br_taken;
  assign br_taken = ((ex_op == OP_BEQZ) && ex_zero) || ((ex_op == OP_BNEZ) && !ex_zero);

  assign stall = (|o_stall) && !br_taken;
  assign fwd_a = o_sel[0];
  assign fwd_b = o_sel[1];
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
  import hz_pkg::*;
#(
  parameter int unsigned REG_W       = 5,
  parameter bit          FULL_BYPASS = 1'b1
) (
  input logic [OP_W-1:0]  dec_op,
  input logic [REG_W-1:0] dec_rs,
  input logic [REG_W-1:0] dec_rt,
  input logic [OP_W-1:0]  ex_op,
  input logic             ex_zero,
  input logic             stall,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b
);
  always_comb begin
    p_taken_no_stall_r8: assert (!(((ex_op == OP_BEQZ) && ex_zero) ||
                                   ((ex_op == OP_BNEZ) && !ex_zero)) || !stall)
      else $error("taken branch in execute but stall raised");
    p_src_t_unread_r3: assert ((dec_op == OP_ALU) || (dec_op == OP_SW) || (fwd_b == SEL_RF))
      else $error("second operand forwarded but not read");
    p_zero_src_r9: assert ((dec_rs != '0) || (fwd_a == SEL_RF))
      else $error("register 0 forwarded on first operand");
    p_zero_both_r9: assert (!((dec_rs == '0) && (dec_rt == '0)) || !stall)
      else $error("stall on register 0 sources");
    if (FULL_BYPASS) begin
      p_stall_only_load_r6: assert (!stall || (ex_op == OP_LW))
        else $error("stall without load in execute");
      p_ex_sel_not_load_r7: assert ((fwd_a != SEL_EX && fwd_b != SEL_EX) || (ex_op != OP_LW))
        else $error("execute forwarding selected for a load");
    end else begin
      p_lock_no_fwd_r5: assert ((fwd_a == SEL_RF) && (fwd_b == SEL_RF))
        else $error("forwarding in interlock-only variant");
    end
  end
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_W(REG_W), .FULL_BYPASS(FULL_BYPASS)) u_chk (
  .dec_op  (dec_op),
  .dec_rs  (dec_rs),
  .dec_rt  (dec_rt),
  .ex_op   (ex_op),
  .ex_zero (ex_zero),
  .stall   (stall),
  .fwd_a   (fwd_a),
  .fwd_b   (fwd_b)
);

// File: tb/hz_ctrl_bench.sv
module hz_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] dec_op, ex_op, mem_op, wb_op;
  logic [4:0] dec_rs, dec_rt, ex_rt, ex_rd, mem_rt, mem_rd, wb_rt, wb_rd;
  logic       ex_zero;
  logic       st_f, st_l;
  logic [1:0] fa_f, fb_f, fa_l, fb_l;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  hz_ctrl #(.REG_W(5), .FULL_BYPASS(1'b1)) u_hz_ctrl (
    .dec_op(dec_op), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .ex_op(ex_op), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_zero(ex_zero),
    .mem_op(mem_op), .mem_rt(mem_rt), .mem_rd(mem_rd),
    .wb_op(wb_op), .wb_rt(wb_rt), .wb_rd(wb_rd),
    .stall(st_f), .fwd_a(fa_f), .fwd_b(fb_f)
  );

  hz_ctrl #(.REG_W(5), .FULL_BYPASS(1'b0)) u_hz_ctrl_lock (
    .dec_op(dec_op), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .ex_op(ex_op), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_zero(ex_zero),
    .mem_op(mem_op), .mem_rt(mem_rt), .mem_rd(mem_rd),
    .wb_op(wb_op), .wb_rt(wb_rt), .wb_rd(wb_rd),
    .stall(st_l), .fwd_a(fa_l), .fwd_b(fb_l)
  );

  // {writes, destination} from R1/R2
  function automatic logic [5:0] wdst(input logic [3:0] op, input logic [4:0] rt, input logic [4:0] rd);
    case (op)
      4'd1:       return {rd != 5'd0, rd};
      4'd2, 4'd3: return {rt != 5'd0, rt};
      4'd8, 4'd10: return {1'b1, 5'd31};
      default:    return 6'd0;
    endcase
  endfunction

  function automatic bit reads_s(input logic [3:0] op);
    return op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10};
  endfunction

  function automatic bit reads_t(input logic [3:0] op);
    return op inside {4'd1, 4'd4};
  endfunction

  // {stall request, select} for one operand (R4..R7)
  function automatic logic [2:0] opnd(input bit full, input logic [4:0] src, input bit en);
    logic [5:0] e, m, w;
    bit he, hm, hw;
    e = wdst(ex_op, ex_rt, ex_rd);
    m = wdst(mem_op, mem_rt, mem_rd);
    w = wdst(wb_op, wb_rt, wb_rd);
    he = en && e[5] && (e[4:0] == src);
    hm = en && m[5] && (m[4:0] == src);
    hw = en && w[5] && (w[4:0] == src);
    if (!full) return {he || hm || hw, 2'd0};
    if (he) return (ex_op == 4'd3) ? 3'b100 : 3'b001;
    if (hm) return 3'b010;
    if (hw) return 3'b011;
    return 3'b000;
  endfunction

  task automatic check_one(input string tag, input bit full, input logic st,
                           input logic [1:0] fa, input logic [1:0] fb);
    logic [2:0] a, b;
    logic es;
    bit taken;
    string ts, tf;
    a = opnd(full, dec_rs, reads_s(dec_op));
    b = opnd(full, dec_rt, reads_t(dec_op));
    taken = ((ex_op == 4'd5) && ex_zero) || ((ex_op == 4'd6) && !ex_zero);
    es = (a[2] || b[2]) && !taken;
    ts = (tag != "") ? tag : (taken ? "R8" : (full ? "R6" : "R5"));
    tf = (tag != "") ? tag : (full ? "R7" : "R5");
    n_vec++;
    if (st !== es || fa !== a[1:0] || fb !== b[1:0]) begin
      n_bad++;
      if (st !== es)
        $display("FAIL %s full=%0d stall actual=%b expected=%b (ops %0d/%0d/%0d/%0d)",
                 ts, full, st, es, dec_op, ex_op, mem_op, wb_op);
      else
        $display("FAIL %s full=%0d fwd actual=%0d/%0d expected=%0d/%0d (ops %0d/%0d/%0d/%0d)",
                 tf, full, fa, fb, a[1:0], b[1:0], dec_op, ex_op, mem_op, wb_op);
    end
  endtask

  task automatic apply(input string tag);
    @(posedge clk);
    #1;
    check_one(tag, 1'b1, st_f, fa_f, fb_f);
    check_one(tag, 1'b0, st_l, fa_l, fb_l);
    @(negedge clk);
  endtask

  task automatic set_all(input logic [3:0] d, input logic [4:0] s, input logic [4:0] t,
                         input logic [3:0] e, input logic [4:0] et, input logic [4:0] ed,
                         input logic z, input logic [3:0] m, input logic [4:0] mt,
                         input logic [4:0] md, input logic [3:0] w, input logic [4:0] wt,
                         input logic [4:0] wd);
    dec_op = d; dec_rs = s; dec_rt = t;
    ex_op = e; ex_rt = et; ex_rd = ed; ex_zero = z;
    mem_op = m; mem_rt = mt; mem_rd = md;
    wb_op = w; wb_rt = wt; wb_rd = wd;
  endtask

  function automatic logic [4:0] pick(input logic [1:0] k);
    case (k)
      2'd0: return 5'd0;
      2'd1: return 5'd1;
      2'd2: return 5'd2;
      default: return 5'd31;
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    set_all(4'd0, 5'd0, 5'd0, 4'd0, 5'd0, 5'd0, 1'b0, 4'd0, 5'd0, 5'd0, 4'd0, 5'd0, 5'd0);
    @(negedge clk);
    // idle pipeline: all NOP bubbles, nothing matches (R9)
    apply("R9");
    // R1: JAL in memory writes 31; ALU in decode reads 31 -> memory select
    set_all(4'd1, 5'd31, 5'd4, 4'd0, 5'd0, 5'd0, 1'b0, 4'd8, 5'd0, 5'd0, 4'd0, 5'd0, 5'd0);
    apply("R1");
    // R1: ALUI in execute writes rt, not rd
    set_all(4'd1, 5'd7, 5'd6, 4'd2, 5'd7, 5'd6, 1'b0, 4'd0, 5'd0, 5'd0, 4'd0, 5'd0, 5'd0);
    apply("R1");
    // R2: ALU writing register 0 does not match a register-0 source
    set_all(4'd1, 5'd0, 5'd0, 4'd1, 5'd0, 5'd0, 1'b0, 4'd3, 5'd0, 5'd0, 4'd1, 5'd0, 5'd0);
    apply("R2");
    // R2: SW in execute never writes
    set_all(4'd1, 5'd3, 5'd3, 4'd4, 5'd3, 5'd3, 1'b0, 4'd0, 5'd0, 5'd0, 4'd0, 5'd0, 5'd0);
    apply("R2");
    // R3: J in decode reads nothing despite matching fields
    set_all(4'd7, 5'd5, 5'd5, 4'd3, 5'd5, 5'd5, 1'b0, 4'd1, 5'd0, 5'd5, 4'd1, 5'd0, 5'd5);
    apply("R3");
    // R3: ALUI reads rs only; rt match ignored
    set_all(4'd2, 5'd9, 5'd4, 4'd3, 5'd4, 5'd0, 1'b0, 4'd0, 5'd0, 5'd0, 4'd0, 5'd0, 5'd0);
    apply("R3");
    // R6: load in execute feeding rt of SW
    set_all(4'd4, 5'd1, 5'd2, 4'd3, 5'd2, 5'd0, 1'b0, 4'd0, 5'd0, 5'd0, 4'd0, 5'd0, 5'd0);
    apply("R6");
    // R7: all three stages write 2, youngest wins
    set_all(4'd1, 5'd2, 5'd2, 4'd1, 5'd0, 5'd2, 1'b0, 4'd2, 5'd2, 5'd0, 4'd3, 5'd2, 5'd0);
    apply("R7");
    // R8: taken BNEZ cancels a load-use stall
    set_all(4'd1, 5'd6, 5'd6, 4'd6, 5'd6, 5'd0, 1'b0, 4'd3, 5'd6, 5'd0, 4'd0, 5'd0, 5'd0);
    apply("R8");
    // exhaustive opcode sweep, fields from {0,1,2,31}
    for (int d = 0; d < 12; d++)
      for (int e = 0; e < 12; e++)
        for (int m = 0; m < 12; m++)
          for (int w = 0; w < 12; w++)
            for (int z = 0; z < 2; z++) begin
              lfsr = lfsr * 32'd1664525 + 32'd1013904223;
              set_all(4'(d), pick(lfsr[31:30]), pick(lfsr[29:28]),
                      4'(e), pick(lfsr[27:26]), pick(lfsr[25:24]), 1'(z),
                      4'(m), pick(lfsr[23:22]), pick(lfsr[21:20]),
                      4'(w), pick(lfsr[19:18]), pick(lfsr[17:16]));
              apply("");
            end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule